// File: doc/BRIEF.md
# Stream Encoder Power Sequencer

This block is the control engine that brings a video stream encoder up and down. It accepts one of four commands on a simple command port: power up, start video, stop video and power down. Each command is carried out as a fixed list of steps. A step either writes one control output or waits for a status input from the encoder core to reach a given level. The outputs are the encoder clock gate, the encoder enable, the reset and enable lines of two internal FIFOs, the video enable, the pixel source select, the CRC enables, and a strobe that tells the secondary-data logic to stop.

Every reset inside a sequence is a four-phase handshake. The block raises the reset, waits for the matching done status to rise, drops the reset and waits for the status to fall. These waits are polled on a microsecond tick, with a short retry budget. When video is stopped, the block waits for the video path to report that it is idle. That wait uses a much longer budget, enough to cover a whole frame at the lowest refresh rate. A wait that runs out of tries ends the sequence with a sticky error. A command that arrives while a sequence is running is refused and is not kept for later.

Top module: `enc_power_seq`

## Requirements
- R1: After reset, busy, done, rejected, err, sdp_clr and every control output are 0, and pix_src is 0.
- R2: cmd_op 0 (power up) sets enc_clk_en to 1, raises enc_rst, waits for enc_rst_done = 1, drops enc_rst, waits for enc_rst_done = 0, then sets enc_en to 1. A command is accepted in a cycle where busy is 0 and cmd_valid is 1, and busy is 1 from the next cycle. Each step takes one cycle. After the last step, busy is 0 and done is 1 for one cycle.
- R3: Reset-done waits sample their status on the first cycle of the wait and then once every SHORT_IV ticks (default 1), at most SHORT_TRIES samples in total (default 10). If the last sample misses, err rises and busy falls. With a tick on every cycle, err rises 12 cycles after busy rises for a power-up whose done status never answers.
- R4: cmd_op 1 (start video) loads pix_src with the src_sel value captured at acceptance and sets vid_en. It then runs the handshake on p2s_rst/p2s_rst_done and sets p2s_en, runs the handshake on cra_rst/cra_rst_done, sets crc_en and crc_cont together, and finally sets cra_en.
- R5: cmd_op 2 (stop video) clears vid_en first. It then waits for vid_active = 0, sampling every LONG_IV ticks (default 10) for at most LONG_TRIES samples (default 5000). After that it gives one single-cycle sdp_clr pulse, then clears p2s_en, then clears cra_en.
- R6: cmd_op 3 (power down) clears enc_en, and one cycle later clears enc_clk_en.
- R7: cmd_valid while busy is 1 produces a one-cycle rejected pulse in the next cycle. The refused command is never executed.
- R8: On a timeout, every control output keeps its value. err stays 1 until the next command is accepted, and it returns to 0 in the same cycle that busy rises.
- R9: Wait counters advance only in cycles with us_tick = 1. With no ticks, a wait samples its status only on its first cycle and never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 power up, 1 start video, 2 stop video, 3 power down |
| src_sel | input | SRC_W | Pixel source captured with a start-video command |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| enc_rst_done | input | 1 | Encoder core reset status |
| p2s_rst_done | input | 1 | Pixel-to-symbol FIFO reset status |
| cra_rst_done | input | 1 | Clock-ramp FIFO reset status |
| vid_active | input | 1 | Video path still transmitting |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| rejected | output | 1 | One-cycle pulse when a command is refused |
| err | output | 1 | Sticky timeout flag |
| enc_clk_en | output | 1 | Encoder clock gate |
| enc_rst | output | 1 | Encoder core reset |
| enc_en | output | 1 | Encoder enable (idle pattern) |
| pix_src | output | SRC_W | Selected pixel source |
| vid_en | output | 1 | Video transmission enable |
| p2s_rst | output | 1 | Pixel-to-symbol FIFO reset |
| p2s_en | output | 1 | Pixel-to-symbol FIFO enable |
| cra_rst | output | 1 | Clock-ramp FIFO reset |
| cra_en | output | 1 | Clock-ramp FIFO enable |
| crc_en | output | 1 | CRC enable |
| crc_cont | output | 1 | CRC continuous mode |
| sdp_clr | output | 1 | One-cycle request to stop secondary data |

## Verification
The hardest case to reach is the long stop-video timeout. It needs the video path to stay active through thousands of 10-tick intervals while the retry count walks up to its limit. The bench holds its video-status responder at 1 and drives the tick on every cycle, so the full budget is used up in about fifty thousand cycles. Two other cases need stimulus the normal responders never give. One is a done status that never answers. The other is a tick that is held off, which shows a wait parked on its entry sample; the responder is then released and ticks resume so the wait completes.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    CMD_PWR_UP   = 2'd0,
    CMD_VID_ON   = 2'd1,
    CMD_VID_OFF  = 2'd2,
    CMD_PWR_DOWN = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    K_WRITE = 2'd0,
    K_WAIT  = 2'd1,
    K_PULSE = 2'd2
  } kind_e;

  typedef enum logic [3:0] {
    T_CLK, T_ENCRST, T_ENCEN, T_SRC, T_VID, T_P2SRST,
    T_P2SEN, T_CRARST, T_CRAEN, T_CRC, T_SDP, T_NONE
  } tgt_e;

  typedef enum logic [1:0] {
    S_ENC = 2'd0,
    S_P2S = 2'd1,
    S_CRA = 2'd2,
    S_VID = 2'd3
  } stat_e;

  typedef struct packed {
    kind_e kind;
    tgt_e  tgt;
    logic  val;
    stat_e stat;
    logic  long_wait;
    logic  last;
  } step_t;

  localparam int MAX_STEPS = 13;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);

  function automatic step_t wr(tgt_e t, logic v, logic l);
    step_t s;
    s.kind = K_WRITE; s.tgt = t; s.val = v; s.stat = S_ENC;
    s.long_wait = 1'b0; s.last = l;
    return s;
  endfunction

  function automatic step_t wt(stat_e st, logic v, logic lw);
    step_t s;
    s.kind = K_WAIT; s.tgt = T_NONE; s.val = v; s.stat = st;
    s.long_wait = lw; s.last = 1'b0;
    return s;
  endfunction

  function automatic step_t pl(tgt_e t);
    step_t s;
    s.kind = K_PULSE; s.tgt = t; s.val = 1'b1; s.stat = S_ENC;
    s.long_wait = 1'b0; s.last = 1'b0;
    return s;
  endfunction

  // Step table: the order inside each command is the behaviour itself.
  function automatic step_t step_at(cmd_e c, logic [STEP_W-1:0] i);
    step_t s;
    s = wr(T_NONE, 1'b0, 1'b1);
    case (c)
      CMD_PWR_UP: case (i)
        0: s = wr(T_CLK, 1'b1, 1'b0);
        1: s = wr(T_ENCRST, 1'b1, 1'b0);
        2: s = wt(S_ENC, 1'b1, 1'b0);
        3: s = wr(T_ENCRST, 1'b0, 1'b0);
        4: s = wt(S_ENC, 1'b0, 1'b0);
        5: s = wr(T_ENCEN, 1'b1, 1'b1);
        default: ;
      endcase
      CMD_VID_ON: case (i)
        0:  s = wr(T_SRC, 1'b1, 1'b0);
        1:  s = wr(T_VID, 1'b1, 1'b0);
        2:  s = wr(T_P2SRST, 1'b1, 1'b0);
        3:  s = wt(S_P2S, 1'b1, 1'b0);
        4:  s = wr(T_P2SRST, 1'b0, 1'b0);
        5:  s = wt(S_P2S, 1'b0, 1'b0);
        6:  s = wr(T_P2SEN, 1'b1, 1'b0);
        7:  s = wr(T_CRARST, 1'b1, 1'b0);
        8:  s = wt(S_CRA, 1'b1, 1'b0);
        9:  s = wr(T_CRARST, 1'b0, 1'b0);
        10: s = wt(S_CRA, 1'b0, 1'b0);
        11: s = wr(T_CRC, 1'b1, 1'b0);
        12: s = wr(T_CRAEN, 1'b1, 1'b1);
        default: ;
      endcase
      CMD_VID_OFF: case (i)
        0: s = wr(T_VID, 1'b0, 1'b0);
        1: s = wt(S_VID, 1'b0, 1'b1);
        2: s = pl(T_SDP);
        3: s = wr(T_P2SEN, 1'b0, 1'b0);
        4: s = wr(T_CRAEN, 1'b0, 1'b1);
        default: ;
      endcase
      default: case (i)
        0: s = wr(T_ENCEN, 1'b0, 1'b0);
        1: s = wr(T_CLK, 1'b0, 1'b1);
        default: ;
      endcase
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pwrseq_poll_timer.sv
module pwrseq_poll_timer #(
  parameter int SHORT_IV    = 1,
  parameter int SHORT_TRIES = 10,
  parameter int LONG_IV     = 10,
  parameter int LONG_TRIES  = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic first,
  input  logic long_sel,
  input  logic tick,
  output logic poll,
  output logic final_try
);
  localparam int MAX_IV = (LONG_IV > SHORT_IV) ? LONG_IV : SHORT_IV;
  localparam int MAX_TR = (LONG_TRIES > SHORT_TRIES) ? LONG_TRIES : SHORT_TRIES;
  localparam int IV_W   = $clog2(MAX_IV + 1);
  localparam int TR_W   = $clog2(MAX_TR + 1);

  logic [IV_W-1:0] iv_cnt, iv_top;
  logic [TR_W-1:0] try_cnt, try_top, cur_try;
  logic            iv_wrap;

  assign iv_top    = long_sel ? IV_W'(LONG_IV - 1) : IV_W'(SHORT_IV - 1);
  assign try_top   = long_sel ? TR_W'(LONG_TRIES - 1) : TR_W'(SHORT_TRIES - 1);
  assign iv_wrap   = tick && (iv_cnt == iv_top);
  assign cur_try   = first ? '0 : try_cnt;
  assign poll      = active && (first || iv_wrap);
  assign final_try = (cur_try == try_top);

  always_ff @(posedge clk) begin
    if (rst) begin
      iv_cnt  <= '0;
      try_cnt <= '0;
    end else if (active) begin
      if (first)
        iv_cnt <= '0;
      else if (tick)
        iv_cnt <= iv_wrap ? '0 : iv_cnt + 1'b1;
      if (poll)
        try_cnt <= cur_try + 1'b1;
    end
  end

  // R3: the number of samples taken never goes past the budget
  p_try_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (active && !first) |-> (try_cnt <= try_top));

  // R9: the interval counter holds in cycles without a tick
  p_iv_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && !$past(first) && !$past(tick) && $past(active && !first)) |-> $stable(iv_cnt));

endmodule

// File: rtl/pwrseq_out_regs.sv
module pwrseq_out_regs
  import pwrseq_pkg::*;
#(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             apply,
  input  tgt_e             tgt,
  input  logic             val,
  input  logic [SRC_W-1:0] src_in,
  output logic             enc_clk_en,
  output logic             enc_rst,
  output logic             enc_en,
  output logic [SRC_W-1:0] pix_src,
  output logic             vid_en,
  output logic             p2s_rst,
  output logic             p2s_en,
  output logic             cra_rst,
  output logic             cra_en,
  output logic             crc_en,
  output logic             crc_cont,
  output logic             sdp_clr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enc_clk_en <= 1'b0; enc_rst <= 1'b0; enc_en  <= 1'b0;
      pix_src    <= '0;   vid_en  <= 1'b0;
      p2s_rst    <= 1'b0; p2s_en  <= 1'b0;
      cra_rst    <= 1'b0; cra_en  <= 1'b0;
      crc_en     <= 1'b0; crc_cont <= 1'b0;
      sdp_clr    <= 1'b0;
    end else begin
      sdp_clr <= 1'b0;
      if (apply) begin
        case (tgt)
          T_CLK:    enc_clk_en <= val;
          T_ENCRST: enc_rst    <= val;
          T_ENCEN:  enc_en     <= val;
          T_SRC:    pix_src    <= src_in;
          T_VID:    vid_en     <= val;
          T_P2SRST: p2s_rst    <= val;
          T_P2SEN:  p2s_en     <= val;
          T_CRARST: cra_rst    <= val;
          T_CRAEN:  cra_en     <= val;
          T_CRC: begin
            crc_en   <= val;
            crc_cont <= val;
          end
          T_SDP:    sdp_clr    <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R2: the core reset is only raised with its clock running
  p_rst_needs_clk_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(enc_rst) |-> enc_clk_en);

  // R6: the clock is gated only after the enable was already low
  p_gate_after_disable_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(enc_clk_en) |-> !$past(enc_en));

  // R5: the secondary-data stop request lasts one cycle
  p_sdp_single_r5: assert property (@(posedge clk) disable iff (rst)
    sdp_clr |=> !sdp_clr);

  // R5: the stop request only comes once video is already off
  p_sdp_after_vid_r5: assert property (@(posedge clk) disable iff (rst)
    sdp_clr |-> !vid_en);

endmodule

// File: rtl/enc_power_seq.sv
module enc_power_seq
  import pwrseq_pkg::*;
#(
  parameter int SRC_W       = 3,
  parameter int SHORT_IV    = 1,
  parameter int SHORT_TRIES = 10,
  parameter int LONG_IV     = 10,
  parameter int LONG_TRIES  = 5000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [SRC_W-1:0] src_sel,
  input  logic             us_tick,
  input  logic             enc_rst_done,
  input  logic             p2s_rst_done,
  input  logic             cra_rst_done,
  input  logic             vid_active,
  output logic             busy,
  output logic             done,
  output logic             rejected,
  output logic             err,
  output logic             enc_clk_en,
  output logic             enc_rst,
  output logic             enc_en,
  output logic [SRC_W-1:0] pix_src,
  output logic             vid_en,
  output logic             p2s_rst,
  output logic             p2s_en,
  output logic             cra_rst,
  output logic             cra_en,
  output logic             crc_en,
  output logic             crc_cont,
  output logic             sdp_clr
);
  cmd_e              cmd_q;
  logic [STEP_W-1:0] step_idx;
  logic [SRC_W-1:0]  src_q;
  logic              first;
  step_t             step;
  logic              in_wait, stat_now, poll, final_try;
  logic              advance, timeout, apply;

  assign step    = step_at(cmd_q, step_idx);
  assign in_wait = busy && (step.kind == K_WAIT);

  always_comb begin
    case (step.stat)
      S_ENC:   stat_now = enc_rst_done;
      S_P2S:   stat_now = p2s_rst_done;
      S_CRA:   stat_now = cra_rst_done;
      default: stat_now = vid_active;
    endcase
  end

  pwrseq_poll_timer #(
    .SHORT_IV(SHORT_IV), .SHORT_TRIES(SHORT_TRIES),
    .LONG_IV(LONG_IV),   .LONG_TRIES(LONG_TRIES)
  ) u_timer (
    .clk(clk), .rst(rst), .active(in_wait), .first(first),
    .long_sel(step.long_wait), .tick(us_tick),
    .poll(poll), .final_try(final_try)
  );

  assign apply   = busy && (step.kind != K_WAIT);
  assign advance = apply || (in_wait && poll && (stat_now == step.val));
  assign timeout = in_wait && poll && (stat_now != step.val) && final_try;

  pwrseq_out_regs #(.SRC_W(SRC_W)) u_outs (
    .clk(clk), .rst(rst), .apply(apply), .tgt(step.tgt), .val(step.val),
    .src_in(src_q),
    .enc_clk_en(enc_clk_en), .enc_rst(enc_rst), .enc_en(enc_en),
    .pix_src(pix_src), .vid_en(vid_en), .p2s_rst(p2s_rst), .p2s_en(p2s_en),
    .cra_rst(cra_rst), .cra_en(cra_en), .crc_en(crc_en),
    .crc_cont(crc_cont), .sdp_clr(sdp_clr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rejected <= 1'b0;
      err      <= 1'b0;
      cmd_q    <= CMD_PWR_UP;
      step_idx <= '0;
      src_q    <= '0;
      first    <= 1'b0;
    end else begin
      done     <= 1'b0;
      rejected <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy     <= 1'b1;
          err      <= 1'b0;
          cmd_q    <= cmd_e'(cmd_op);
          src_q    <= src_sel;
          step_idx <= '0;
          first    <= 1'b1;
        end
      end else begin
        rejected <= cmd_valid;
        if (timeout) begin
          busy <= 1'b0;
          err  <= 1'b1;
        end else if (advance) begin
          first    <= 1'b1;
          step_idx <= step_idx + 1'b1;
          if (step.last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          first <= 1'b0;
        end
      end
    end
  end

  // R2: completion is reported only with the sequencer idle
  p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: a refusal only follows a cycle in which a sequence was running
  p_reject_when_busy_r7: assert property (@(posedge clk) disable iff (rst)
    rejected |-> $past(busy));

  // R8: the error flag clears only when a new command starts
  p_err_clear_on_accept_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(err) |-> busy);

  // R8: a timeout never also reports completion
  p_err_no_done_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (!done && !busy));

  // R9: with budgets above one sample, a timeout needs a tick in its cycle
  p_timeout_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(err) && (SHORT_TRIES > 1) && (LONG_TRIES > 1)) |-> $past(us_tick));

endmodule

// File: tb/enc_power_seq_bench.sv
module enc_power_seq_bench;
  localparam int SRC_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [SRC_W-1:0] src_sel = '0;
  logic us_tick = 1'b0;
  logic enc_rst_done = 1'b0, p2s_rst_done = 1'b0, cra_rst_done = 1'b0, vid_active = 1'b0;
  logic busy, done, rejected, err, enc_clk_en, enc_rst, enc_en, vid_en;
  logic p2s_rst, p2s_en, cra_rst, cra_en, crc_en, crc_cont, sdp_clr;
  logic [SRC_W-1:0] pix_src;

  always #5 clk = ~clk;

  enc_power_seq #(.SRC_W(SRC_W)) u_enc_power_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .src_sel(src_sel), .us_tick(us_tick), .enc_rst_done(enc_rst_done),
    .p2s_rst_done(p2s_rst_done), .cra_rst_done(cra_rst_done),
    .vid_active(vid_active), .busy(busy), .done(done), .rejected(rejected),
    .err(err), .enc_clk_en(enc_clk_en), .enc_rst(enc_rst), .enc_en(enc_en),
    .pix_src(pix_src), .vid_en(vid_en), .p2s_rst(p2s_rst), .p2s_en(p2s_en),
    .cra_rst(cra_rst), .cra_en(cra_en), .crc_en(crc_en), .crc_cont(crc_cont),
    .sdp_clr(sdp_clr)
  );

  int nchk = 0, nfail = 0;
  int tick_div = 0, cyc = 0, total = 0;
  int enc_dly = 3, p2s_dly = 2, cra_dly = 2, vid_dly = 4;
  int enc_cnt = 0, p2s_cnt = 0, cra_cnt = 0, vid_cnt = 0;
  logic enc_r = 0, p2s_r = 0, cra_r = 0, vid_r = 0;
  logic stuck_enc = 0, stuck_vid = 0;
  int sdp_seen = 0, order_bad = 0;
  logic prev_clk = 0, prev_en = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  // Status responders and tick source, all driven away from the active edge
  always @(negedge clk) begin
    if (enc_rst != enc_r) begin
      enc_cnt++; if (enc_cnt >= enc_dly) begin enc_r = enc_rst; enc_cnt = 0; end
    end else enc_cnt = 0;
    if (p2s_rst != p2s_r) begin
      p2s_cnt++; if (p2s_cnt >= p2s_dly) begin p2s_r = p2s_rst; p2s_cnt = 0; end
    end else p2s_cnt = 0;
    if (cra_rst != cra_r) begin
      cra_cnt++; if (cra_cnt >= cra_dly) begin cra_r = cra_rst; cra_cnt = 0; end
    end else cra_cnt = 0;
    if (vid_en != vid_r) begin
      vid_cnt++; if (vid_cnt >= vid_dly) begin vid_r = vid_en; vid_cnt = 0; end
    end else vid_cnt = 0;
    enc_rst_done = stuck_enc ? 1'b0 : enc_r;
    p2s_rst_done = p2s_r;
    cra_rst_done = cra_r;
    vid_active   = stuck_vid ? 1'b1 : vid_r;
    cyc++;
    us_tick = (tick_div != 0) && (cyc % tick_div == 0);
  end

  // Behavioural reference model: a queue of pending steps per command
  typedef struct { int kind; int tgt; int val; int stat; int lng; } mstep_t;
  mstep_t q[$];
  int m_clk, m_erst, m_een, m_src, m_vid, m_prst, m_pen, m_crst, m_cen, m_crc, m_sdp;
  int m_busy, m_done, m_rej, m_err, m_first, m_ivc, m_tries, m_srcl;

  task automatic pw(input int t, input int v);
    mstep_t s; s.kind = 0; s.tgt = t; s.val = v; s.stat = 0; s.lng = 0; q.push_back(s);
  endtask
  task automatic pwt(input int st, input int v, input int l);
    mstep_t s; s.kind = 1; s.tgt = 0; s.val = v; s.stat = st; s.lng = l; q.push_back(s);
  endtask

  task automatic load_cmd(input int op);
    q.delete();
    case (op)
      0: begin pw(0,1); pw(1,1); pwt(0,1,0); pw(1,0); pwt(0,0,0); pw(2,1); end
      1: begin pw(3,1); pw(4,1); pw(5,1); pwt(1,1,0); pw(5,0); pwt(1,0,0); pw(6,1);
               pw(7,1); pwt(2,1,0); pw(7,0); pwt(2,0,0); pw(9,1); pw(8,1); end
      2: begin pw(4,0); pwt(3,0,1); pw(10,1); pw(6,0); pw(8,0); end
      default: begin pw(2,0); pw(0,0); end
    endcase
  endtask

  task automatic apply_step(input mstep_t s);
    case (s.tgt)
      0: m_clk = s.val;  1: m_erst = s.val; 2: m_een = s.val; 3: m_src = m_srcl;
      4: m_vid = s.val;  5: m_prst = s.val; 6: m_pen = s.val; 7: m_crst = s.val;
      8: m_cen = s.val;  9: m_crc = s.val;  default: m_sdp = 1;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_clk = 0; m_erst = 0; m_een = 0; m_src = 0; m_vid = 0; m_prst = 0; m_pen = 0;
      m_crst = 0; m_cen = 0; m_crc = 0; m_sdp = 0; m_busy = 0; m_done = 0; m_rej = 0;
      m_err = 0; m_first = 0; m_ivc = 0; m_tries = 0; m_srcl = 0; q.delete();
    end else begin
      m_done = 0; m_rej = 0; m_sdp = 0;
      if (m_busy == 0) begin
        if (cmd_valid) begin
          load_cmd(int'(cmd_op)); m_busy = 1; m_err = 0; m_first = 1; m_srcl = int'(src_sel);
        end
      end else begin
        mstep_t s;
        m_rej = cmd_valid ? 1 : 0;
        s = q[0];
        if (s.kind != 1) begin
          apply_step(s); void'(q.pop_front()); m_first = 1;
          if (q.size() == 0) begin m_busy = 0; m_done = 1; end
        end else begin
          int iv, lim, cur, sv; bit pol;
          iv  = s.lng ? 10 : 1;
          lim = s.lng ? 5000 : 10;
          pol = (m_first != 0) || (us_tick && m_ivc == iv - 1);
          cur = m_first ? 0 : m_tries;
          if (m_first) m_ivc = 0;
          else if (us_tick) m_ivc = (m_ivc == iv - 1) ? 0 : m_ivc + 1;
          case (s.stat)
            0: sv = enc_rst_done; 1: sv = p2s_rst_done; 2: sv = cra_rst_done; default: sv = vid_active;
          endcase
          if (pol && sv == s.val) begin
            void'(q.pop_front()); m_first = 1;
            if (q.size() == 0) begin m_busy = 0; m_done = 1; end
          end else if (pol && cur == lim - 1) begin
            m_busy = 0; m_err = 1; q.delete();
          end else begin
            if (pol) m_tries = cur + 1;
            m_first = 0;
          end
        end
      end
    end
  end

  // Per-cycle comparison against the model, plus ordering monitors
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 power group", {enc_clk_en, enc_rst, enc_en}, {m_clk[0], m_erst[0], m_een[0]});
      chk("R4 video group", {pix_src, vid_en, p2s_rst, p2s_en, cra_rst, cra_en, crc_en, crc_cont},
          {m_src[SRC_W-1:0], m_vid[0], m_prst[0], m_pen[0], m_crst[0], m_cen[0], m_crc[0], m_crc[0]});
      chk("R5 sdp_clr", sdp_clr, m_sdp);
      chk("R2 busy/done", {busy, done}, {m_busy[0], m_done[0]});
      chk("R7 rejected", rejected, m_rej);
      chk("R8 err", err, m_err);
      if (sdp_clr) sdp_seen++;
      if (prev_clk && !enc_clk_en && prev_en) order_bad++;
      prev_clk = enc_clk_en; prev_en = enc_en;
    end
    total++;
    if (total > 190000) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", total, 190000);
      finish_run();
    end
  end

  task automatic issue(input int op, input int src);
    cmd_valid = 1'b1; cmd_op = 2'(op); src_sel = SRC_W'(src);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 outputs", {enc_clk_en, enc_rst, enc_en, vid_en, p2s_en, cra_en, crc_en, sdp_clr, err}, 0);
    chk("R1 pix_src", pix_src, 0);

    // R2 power up, with a refused command during the run (R7)
    tick_div = 4; enc_dly = 3;
    issue(0, 0);
    chk("R2 busy after accept", busy, 1);
    issue(1, 6);
    chk("R7 reject pulse", rejected, 1);
    wait_idle();
    chk("R2 done pulse", done, 1);
    chk("R2 enabled", {enc_clk_en, enc_rst, enc_en}, 3'b101);
    chk("R7 refused command not run", vid_en, 0);

    // R4 start video
    p2s_dly = 2; cra_dly = 5;
    issue(1, 5);
    wait_idle();
    chk("R4 source", pix_src, 5);
    chk("R4 enables", {vid_en, p2s_en, cra_en, crc_en, crc_cont, p2s_rst, cra_rst}, 7'b1111100);

    // R5 stop video with a slow video path
    vid_dly = 30; tick_div = 2; sdp_seen = 0;
    issue(2, 0);
    @(negedge clk);
    chk("R5 video cleared first", {vid_en, p2s_en}, 2'b01);
    wait_idle();
    chk("R5 sdp pulse count", sdp_seen, 1);
    chk("R5 fifos off", {p2s_en, cra_en, err}, 0);

    // R6 power down
    issue(3, 0);
    wait_idle();
    chk("R6 off", {enc_en, enc_clk_en}, 0);
    chk("R6 order", order_bad, 0);

    // R3 timeout with a done status that never answers
    tick_div = 1; stuck_enc = 1;
    issue(0, 0);
    n = 0;
    while (!err && n < 100) begin @(negedge clk); n++; end
    chk("R3 timeout latency", n, 12);
    chk("R3 busy dropped", busy, 0);
    chk("R8 outputs held", {enc_clk_en, enc_rst, enc_en}, 3'b110);
    repeat (20) @(negedge clk);
    chk("R8 err sticky", err, 1);
    issue(3, 0);
    chk("R8 err cleared on accept", {err, busy}, 2'b01);
    wait_idle();

    // R9 no ticks: the wait parks on its entry sample
    tick_div = 0;
    issue(0, 0);
    repeat (300) @(negedge clk);
    chk("R9 parked busy", {busy, err}, 2'b10);
    stuck_enc = 0;
    repeat (20) @(negedge clk);
    chk("R9 no sample without tick", busy, 1);
    tick_div = 1;
    wait_idle();
    chk("R9 completes with ticks", {err, enc_en}, 2'b01);

    // R5 long timeout with the video path held active
    issue(1, 3);
    wait_idle();
    stuck_vid = 1;
    issue(2, 0);
    wait_idle();
    chk("R5 long timeout err", err, 1);
    chk("R8 fifo state held", {vid_en, p2s_en, cra_en}, 3'b011);
    stuck_vid = 0; sdp_seen = 0;
    issue(2, 0);
    wait_idle();
    chk("R5 retry completes", {err, p2s_en, cra_en}, 0);
    chk("R5 sdp after retry", sdp_seen, 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule